// File: doc/BRIEF.md
# Segment Row Latch with Display Modes

This block keeps one row of pixel data for the segment drivers of a passive-matrix display. On each pulse of the line strobe it takes a full row from the display memory read bus. It then shows that row on the segment outputs after applying the display-mode controls that the instruction decoder sets.

There are three mode controls. Blanking turns every segment off. Full lighting turns every segment on. Inversion shows the complement of the stored row. The modes act only on the path from the latch to the outputs. The stored row and the display memory are never rewritten by them, so clearing a mode shows the original data again at the next strobe.

Mode flags are sampled on the same strobe as the row data. A flag that changes partway through a row period therefore does not disturb the row that is currently shown.

Top module: `seg_row_latch`

## Requirements
- R1: After reset every segment output is 0 (display blanked). The outputs stay 0 until the first latch strobe, whatever the row bus carries.
- R2: When a strobe is sampled high at a rising edge with `disp_on`=1, `full_on`=0 and `rev_on`=0, then from that edge on `seg_out` equals the `row_data` sampled at that edge, bit for bit (bit i drives segment i).
- R3: In cycles where the strobe is sampled low, `seg_out` keeps its value, whatever `row_data` does.
- R4: A strobe sampled with `disp_on`=0 makes every output 0, whatever `rev_on`, `full_on` and `row_data` are. This is the highest-priority mode.
- R5: A strobe sampled with `disp_on`=1 and `full_on`=1 makes every output 1, whatever `rev_on` is.
- R6: A strobe sampled with `disp_on`=1, `full_on`=0 and `rev_on`=1 makes `seg_out` the bitwise complement of the captured row.
- R7: Changes to `disp_on`, `rev_on` and `full_on` between strobes have no effect on `seg_out` until the next strobe samples them.
- R8: Strobes in back-to-back cycles each capture a new row and a new mode. The output follows every one of them, one edge after each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_data | input | SEG_W (100) | Row read from display memory, bit i for segment i |
| latch_stb | input | 1 | One-cycle line strobe; captures row and modes |
| disp_on | input | 1 | 1 = display enabled, 0 = blank all segments |
| rev_on | input | 1 | 1 = show the inverted row |
| full_on | input | 1 | 1 = light all segments |
| seg_out | output | SEG_W (100) | Per-segment pixel data to the drivers |

## Verification
The bench aims at the order of mode priority. It asserts blanking together with full lighting, and full lighting together with inversion. A design with the order wrong would show all ones in the first case or an inverted row in the second.

It changes the mode flags and the row bus between strobes. A design that applies the flags combinationally would switch the display partway through a row.

It fires strobes in consecutive cycles with different rows. A design that needs an idle cycle between captures, or that latches on an edge of the strobe, would miss one of them.

It checks the blank state after reset while the row bus carries noise. A design that captures data before the first strobe would show that noise.

// File: rtl/seg_row_latch_pkg.sv
// Package: shared types for the segment row latch.
// Holds the resolved view encoding and the priority function that
// maps raw mode flags onto it. Assumes no other state.
package seg_row_latch_pkg;

    // How the latched row is presented on the segment outputs.
    typedef enum logic [1:0] {
        VIEW_BLANK  = 2'd0,
        VIEW_FULL   = 2'd1,
        VIEW_INVERT = 2'd2,
        VIEW_TRUE   = 2'd3
    } view_e;

    // Raw mode flags as they arrive from the instruction decoder.
    typedef struct packed {
        logic on;
        logic invert;
        logic full;
    } mode_t;

    // Priority: blank beats full lighting, full lighting beats inversion.
    function automatic view_e resolve_view(input mode_t m);
        view_e v;
        if (!m.on)
            v = VIEW_BLANK;
        else if (m.full)
            v = VIEW_FULL;
        else if (m.invert)
            v = VIEW_INVERT;
        else
            v = VIEW_TRUE;
        return v;
    endfunction

endpackage

// File: rtl/seg_mode_capture.sv
// Module: seg_mode_capture
// Samples the three mode flags on the line strobe and holds the resolved
// view until the next strobe, so flag changes never act mid-row.
// Assumes: strobe is synchronous to clk; reset is synchronous, active low.
module seg_mode_capture
    import seg_row_latch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  mode_t mode_in,
    output view_e view
);

    view_e view_q;

    // Hold the resolved view; reload it only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            view_q <= VIEW_BLANK;
        else if (stb)
            view_q <= resolve_view(mode_in);
    end

    assign view = view_q;

endmodule

// File: rtl/seg_row_bank.sv
// Module: seg_row_bank
// Stores one slice of the display row. It loads the slice on the line
// strobe and leaves it untouched otherwise. Modes never write here.
// Assumes: synchronous active-low reset clears the slice.
module seg_row_bank #(
    parameter int BANK_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] dout
);

    logic [BANK_W-1:0] slice_q;

    // Capture this bank's slice of the row on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slice_q <= '0;
        else if (stb)
            slice_q <= din;
    end

    assign dout = slice_q;

endmodule

// File: rtl/seg_view.sv
// Module: seg_view
// Applies the resolved view to one stored slice. The output is blanked,
// fully lit, inverted or passed through. Purely combinational.
// Assumes: view comes from a register, so the output is glitch-bounded.
module seg_view
    import seg_row_latch_pkg::*;
#(
    parameter int BANK_W = 20
) (
    input  view_e             view,
    input  logic [BANK_W-1:0] row,
    output logic [BANK_W-1:0] seg
);

    // Select the presentation of this slice.
    always_comb begin
        unique case (view)
            VIEW_BLANK:  seg = '0;
            VIEW_FULL:   seg = '1;
            VIEW_INVERT: seg = ~row;
            default:     seg = row;
        endcase
    end

endmodule

// File: rtl/seg_row_latch.sv
// Module: seg_row_latch (top)
// Row latch between display memory and segment drivers. It captures the
// row and the mode flags together on latch_stb and presents the row with
// the display modes applied. Stored data is never altered by a mode.
// Assumes: SEG_W is a multiple of BANK_W; one-cycle strobes; reset is
// synchronous and active low.
module seg_row_latch
    import seg_row_latch_pkg::*;
#(
    parameter int SEG_W  = 100,
    parameter int BANK_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] row_data,
    input  logic             latch_stb,
    input  logic             disp_on,
    input  logic             rev_on,
    input  logic             full_on,
    output logic [SEG_W-1:0] seg_out
);

    localparam int NUM_BANKS = SEG_W / BANK_W;

    mode_t mode_in;
    view_e view;

    // Group the raw flags for the capture stage.
    always_comb begin
        mode_in.on     = disp_on;
        mode_in.invert = rev_on;
        mode_in.full   = full_on;
    end

    seg_mode_capture u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (latch_stb),
        .mode_in (mode_in),
        .view    (view)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] stored;

        seg_row_bank #(.BANK_W(BANK_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (latch_stb),
            .din   (row_data[b*BANK_W +: BANK_W]),
            .dout  (stored)
        );

        seg_view #(.BANK_W(BANK_W)) u_view (
            .view (view),
            .row  (stored),
            .seg  (seg_out[b*BANK_W +: BANK_W])
        );
    end

endmodule

// File: rtl/seg_row_latch_chk.sv
// Module: seg_row_latch_chk
// Port-level properties of the row latch. Attached to every instance of
// the top by the bind below.
module seg_row_latch_chk #(
    parameter int SEG_W = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEG_W-1:0] row_data,
    input logic             latch_stb,
    input logic             disp_on,
    input logic             rev_on,
    input logic             full_on,
    input logic [SEG_W-1:0] seg_out
);

    p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> seg_out == '0);

    p_pass_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(latch_stb) && $past(disp_on) && !$past(full_on) && !$past(rev_on))
        |-> seg_out == $past(row_data));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(latch_stb)) |-> $stable(seg_out));

    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(latch_stb) && !$past(disp_on)) |-> seg_out == '0);

    p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(latch_stb) && $past(disp_on) && $past(full_on)) |-> seg_out == '1);

    p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(latch_stb) && $past(disp_on) && !$past(full_on) && $past(rev_on))
        |-> seg_out == ~$past(row_data));

endmodule

bind seg_row_latch seg_row_latch_chk #(.SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_data  (row_data),
    .latch_stb (latch_stb),
    .disp_on   (disp_on),
    .rev_on    (rev_on),
    .full_on   (full_on),
    .seg_out   (seg_out)
);

// File: tb/tb_seg_row_latch.sv
// Scoreboard bench: the driver pushes one expected output per cycle, and
// the monitor pops and compares just after each rising edge.
module tb_seg_row_latch;

    localparam int W = 100;

    typedef struct {
        logic [W-1:0] v;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] row_data = '0;
    logic         latch_stb = 1'b0;
    logic         disp_on = 1'b0;
    logic         rev_on = 1'b0;
    logic         full_on = 1'b0;
    logic [W-1:0] seg_out;

    item_t        q[$];
    logic [W-1:0] shown = '0;
    int           checks = 0;
    int           errors = 0;
    logic         mon_en = 1'b0;

    always #2 clk = ~clk;

    seg_row_latch dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_data  (row_data),
        .latch_stb (latch_stb),
        .disp_on   (disp_on),
        .rev_on    (rev_on),
        .full_on   (full_on),
        .seg_out   (seg_out)
    );

    function automatic logic [W-1:0] pat(input int s);
        logic [W-1:0] p;
        for (int i = 0; i < W; i++) p[i] = (((i * s) + s) % 3) == 0;
        return p;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] r,
                                           input logic on, input logic inv,
                                           input logic full);
        if (!on) return '0;
        if (full) return '1;
        if (inv) return ~r;
        return r;
    endfunction

    // Drive one cycle and push the output expected after the next edge.
    task automatic drive(input logic [W-1:0] r, input logic stb, input logic on,
                         input logic inv, input logic full, input string tag);
        item_t it;
        @(negedge clk);
        row_data = r; latch_stb = stb; disp_on = on; rev_on = inv; full_on = full;
        if (stb) shown = model(r, on, inv, full);
        it.v = shown; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare the output one step after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (seg_out !== it.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, seg_out, it.v);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with noise on the inputs
        row_data = pat(5); latch_stb = 1'b1; disp_on = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; latch_stb = 1'b0;
        @(posedge clk); #1;
        checks++;
        if (seg_out !== '0) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=%h", seg_out, {W{1'b0}});
        end
        mon_en = 1'b1;
        drive(pat(7), 1'b0, 1'b1, 1'b0, 1'b0, "R1 idle after reset");
        drive(pat(2), 1'b0, 1'b1, 1'b1, 1'b0, "R1 idle after reset");
        // R4: display off with every other mode set
        drive(pat(4), 1'b1, 1'b0, 1'b1, 1'b1, "R4 blank beats full");
        // R2: normal pass-through
        drive(pat(1), 1'b1, 1'b1, 1'b0, 1'b0, "R2 pass row");
        // R3 / R7: row and flags change without a strobe
        drive(pat(8), 1'b0, 1'b0, 1'b0, 1'b0, "R7 off flag held");
        drive(pat(9), 1'b0, 1'b1, 1'b1, 1'b0, "R7 invert flag held");
        drive(pat(10), 1'b0, 1'b1, 1'b0, 1'b1, "R3 row ignored");
        // R6: inversion
        drive(pat(11), 1'b1, 1'b1, 1'b1, 1'b0, "R6 invert row");
        drive(pat(12), 1'b0, 1'b1, 1'b0, 1'b0, "R7 invert held");
        // R5: full beats inversion
        drive(pat(13), 1'b1, 1'b1, 1'b1, 1'b1, "R5 full beats invert");
        drive(pat(14), 1'b0, 1'b0, 1'b0, 1'b0, "R3 full held");
        // return to normal: stored row shown unchanged
        drive(pat(13), 1'b1, 1'b1, 1'b0, 1'b0, "R2 row after full");
        // R8: back-to-back strobes, modes change each cycle
        for (int k = 0; k < 8; k++)
            drive(pat(20 + k), 1'b1, (k % 4) != 3, (k % 2) == 1, (k % 3) == 2, "R8 back-to-back");
        drive({W{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b0, "R2 all ones");
        drive({W{1'b1}}, 1'b1, 1'b1, 1'b1, 1'b0, "R6 invert all ones");
        drive('0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 invert zeros");
        drive(pat(3), 1'b0, 1'b0, 1'b0, 1'b0, "R3 final hold");
        @(negedge clk);
        latch_stb = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule